// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block collects receive-error event pulses from several line ports into sticky status bits. Each port owns one status register, and each source inside a port has one bit in it. A status bit, once set, stays set until software reads the register that holds it. The read strobe, together with the register address, clears every bit of that port in one cycle.

Each status bit has its own enable bit in a mask vector. A global enable and a cell-error-only mode then decide whether that bit may drive the shared active-low interrupt line. In cell-error-only mode, only the three cell-error sources of each port count towards the interrupt: bad header checksum, short cell and received symbol error. All other sources are held back in that mode. Normal operation runs with the global enable on and cell-error-only mode off.

Software waits for the interrupt line to fall. It then reads the status register of each port to find the cause, and each read releases the line for further events.

Top module: `sticky_irq_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every status bit is 0 and `irq_n_o` is 1.
- R2: A one-cycle pulse on an `evt_i` bit sets the matching `status_o` bit after the next clock edge. The bit then holds until its port is read, with no further pulses. Bit `p*NUM_SRC+s` belongs to port `p`, source `s`.
- R3: A cycle with `rd_stb_i` high clears all status bits of port `rd_addr_i` after the clock edge. Status bits of every other port are left unchanged.
- R4: An event that arrives in the same cycle as a clearing read of its own port leaves its status bit set.
- R5: Status bits latch events whatever the values of the mask, the global enable and the mode.
- R6: A status bit drives the interrupt only while its `src_mask_i` bit is 1. With all mask bits 0, `irq_n_o` stays 1.
- R7: While `irq_en_i` is 0, `irq_n_o` is 1 one cycle later, whatever the status.
- R8: While `cell_err_only_i` is 1, only sources 0, 1 and 2 of each port can pull `irq_n_o` low. These are bad header checksum, short cell and symbol error. Sources 3 and above are ignored for the interrupt.
- R9: `irq_n_o` is a registered output. It falls on the second clock edge after an enabled event pulse, and rises on the second clock edge after the read that clears the last enabled status bit.
- R10: Once reads have cleared every status bit that is both enabled and allowed by the mode, `irq_n_o` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_PORTS*NUM_SRC | One-cycle event pulses, port-major order |
| rd_stb_i | input | 1 | Status register read strobe, clears the addressed port |
| rd_addr_i | input | ADDR_W | Port index of the status register being read |
| src_mask_i | input | NUM_PORTS*NUM_SRC | Interrupt enable bit per status bit, 1 = enabled |
| irq_en_i | input | 1 | Global interrupt enable |
| cell_err_only_i | input | 1 | Restrict the interrupt to cell-error sources |
| status_o | output | NUM_PORTS*NUM_SRC | Sticky status registers, port-major order |
| irq_n_o | output | 1 | Registered active-low interrupt |

## Verification
The bench builds the block with its default parameters: four ports of five sources each. This gives 20 status bits, with two non-cell-error sources per port that the cell-error-only mode must hold back. With four ports, the bench can read one port while events sit in its neighbours, and so show that a read clears only its own register. The stimulus table covers these cases and a read that coincides with a fresh event on the same port. Directed steps then measure the two-edge latency of the interrupt line on both its fall and its rise.

// File: rtl/sticky_irq_pkg.sv
// Shared constants for the sticky interrupt status controller.
// Assumes the cell-error sources occupy the lowest source indices of a port.
package sticky_irq_pkg;

    // Source index of each receive cell error within a port register.
    typedef enum int unsigned {
        SRC_BAD_HDR    = 0,
        SRC_SHORT_CELL = 1,
        SRC_SYMBOL     = 2
    } cell_err_src_e;

    localparam int unsigned CELL_ERR_SRCS = 3;

    // True when a source index is one of the receive cell errors.
    function automatic logic is_cell_err(input int unsigned src_idx);
        return src_idx < CELL_ERR_SRCS;
    endfunction

endpackage

// File: rtl/isc_port_status.sv
// Sticky status register for one port.
// Sets a bit on an event pulse and clears the register on a read. An event
// in the same cycle as the read wins over the clear.
// Assumes events are one-cycle pulses and the clear is already decoded.
module isc_port_status #(
    parameter int unsigned NUM_SRC = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               clr_i,
    output logic [NUM_SRC-1:0] stat_o
);

    // Hold, clear or set the sticky bits.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            stat_o <= '0;
        end else begin
            stat_o <= (clr_i ? '0 : stat_o) | evt_i;
        end
    end

endmodule

// File: rtl/isc_src_gate.sv
// Qualifies every status bit with its mask bit and with the cell-error-only
// mode, and reduces the result to a single pending flag.
// Assumes port-major bit order: bit p*NUM_SRC+s is port p, source s.
module isc_src_gate
    import sticky_irq_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned NUM_SRC   = 5
) (
    input  logic [NUM_PORTS*NUM_SRC-1:0] stat_i,
    input  logic [NUM_PORTS*NUM_SRC-1:0] mask_i,
    input  logic                         cell_only_i,
    output logic                         pend_o
);

    localparam int unsigned TOTAL = NUM_PORTS * NUM_SRC;

    logic [TOTAL-1:0] elig;

    for (genvar b = 0; b < TOTAL; b++) begin : g_bit
        if (is_cell_err(b % NUM_SRC)) begin : g_cell
            // Cell-error sources pass in both modes.
            assign elig[b] = stat_i[b] & mask_i[b];
        end else begin : g_other
            // Other sources are held back in cell-error-only mode.
            assign elig[b] = stat_i[b] & mask_i[b] & ~cell_only_i;
        end
    end

    // Any enabled, allowed status bit makes the interrupt pending.
    assign pend_o = |elig;

endmodule

// File: rtl/isc_irq_out.sv
// Registered active-low interrupt driver gated by the global enable.
// Assumes pend_i is a combinational function of registered status.
module isc_irq_out (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pend_i,
    input  logic en_i,
    output logic irq_n_o
);

    // Register the inverted, enabled pending flag so the pin cannot glitch.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            irq_n_o <= 1'b1;
        end else begin
            irq_n_o <= ~(pend_i & en_i);
        end
    end

endmodule

// File: rtl/sticky_irq_ctrl.sv
// Sticky interrupt status controller, top level.
// Holds one clear-on-read status register per port and drives the masked,
// mode-gated interrupt.
// Assumes NUM_SRC >= 3 so that the cell-error sources exist in every port.
module sticky_irq_ctrl #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned NUM_SRC   = 5,
    localparam int unsigned TOTAL    = NUM_PORTS * NUM_SRC,
    localparam int unsigned ADDR_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [TOTAL-1:0]  evt_i,
    input  logic              rd_stb_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [TOTAL-1:0]  src_mask_i,
    input  logic              irq_en_i,
    input  logic              cell_err_only_i,
    output logic [TOTAL-1:0]  status_o,
    output logic              irq_n_o
);

    logic pend;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic port_clr;

        // Decode the read strobe for this port's register.
        assign port_clr = rd_stb_i && (rd_addr_i == ADDR_W'(p));

        isc_port_status #(
            .NUM_SRC (NUM_SRC)
        ) u_stat (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .evt_i  (evt_i[p*NUM_SRC +: NUM_SRC]),
            .clr_i  (port_clr),
            .stat_o (status_o[p*NUM_SRC +: NUM_SRC])
        );
    end

    isc_src_gate #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_SRC   (NUM_SRC)
    ) u_gate (
        .stat_i      (status_o),
        .mask_i      (src_mask_i),
        .cell_only_i (cell_err_only_i),
        .pend_o      (pend)
    );

    isc_irq_out u_irq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pend_i  (pend),
        .en_i    (irq_en_i),
        .irq_n_o (irq_n_o)
    );

endmodule

// File: rtl/sticky_irq_ctrl_chk.sv
// Property checker for sticky_irq_ctrl, attached through bind.
// Observes ports only; the clear map and the cell-error map are rebuilt here.
module sticky_irq_ctrl_chk
    import sticky_irq_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned NUM_SRC   = 5,
    localparam int unsigned TOTAL    = NUM_PORTS * NUM_SRC,
    localparam int unsigned ADDR_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [TOTAL-1:0]  evt_i,
    input logic              rd_stb_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [TOTAL-1:0]  src_mask_i,
    input logic              irq_en_i,
    input logic              cell_err_only_i,
    input logic [TOTAL-1:0]  status_o,
    input logic              irq_n_o
);

    logic [TOTAL-1:0] rd_clr;
    logic [TOTAL-1:0] cell_sel;

    // Bits that the current read strobe addresses.
    always_comb begin
        rd_clr = '0;
        for (int unsigned b = 0; b < TOTAL; b++) begin
            rd_clr[b] = rd_stb_i && (rd_addr_i == ADDR_W'(b / NUM_SRC));
        end
    end

    // Bits that belong to cell-error sources.
    always_comb begin
        cell_sel = '0;
        for (int unsigned b = 0; b < TOTAL; b++) begin
            cell_sel[b] = is_cell_err(b % NUM_SRC);
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (status_o == '0) && irq_n_o);

    // R2
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((status_o & $past(status_o & ~rd_clr)) == $past(status_o & ~rd_clr)));

    // R3
    read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_stb_i |=> ((status_o & $past(rd_clr & ~evt_i)) == '0));

    // R4
    event_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((status_o & $past(evt_i)) == $past(evt_i)));

    // R6
    mask_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_o & src_mask_i) == '0) |=> irq_n_o);

    // R7
    global_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_en_i |=> irq_n_o);

    // R8
    cell_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cell_err_only_i && ((status_o & src_mask_i & cell_sel) == '0) |=> irq_n_o);

endmodule

bind sticky_irq_ctrl sticky_irq_ctrl_chk #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_SRC   (NUM_SRC)
) u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .evt_i           (evt_i),
    .rd_stb_i        (rd_stb_i),
    .rd_addr_i       (rd_addr_i),
    .src_mask_i      (src_mask_i),
    .irq_en_i        (irq_en_i),
    .cell_err_only_i (cell_err_only_i),
    .status_o        (status_o),
    .irq_n_o         (irq_n_o)
);

// File: tb/sticky_irq_ctrl_tb.sv
`timescale 1ns/1ps
module sticky_irq_ctrl_tb;

    localparam int unsigned NP = 4;
    localparam int unsigned NS = 5;
    localparam int unsigned TW = NP * NS;

    typedef struct packed {
        logic [19:0] ev;
        logic        rd;
        logic [1:0]  addr;
        logic [19:0] mask;
        logic        en;
        logic        conly;
        logic [19:0] exp_stat;
        logic        exp_irq_n;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        vec_t'{20'h00001, 1'b0, 2'd0, 20'hFFFFF, 1'b1, 1'b0, 20'h00001, 1'b0}, // R2 R6 set, fires
        vec_t'{20'h00000, 1'b1, 2'd1, 20'hFFFFF, 1'b1, 1'b0, 20'h00001, 1'b0}, // R3 other port kept
        vec_t'{20'h00000, 1'b1, 2'd0, 20'hFFFFF, 1'b1, 1'b0, 20'h00000, 1'b1}, // R3 R10 clear, release
        vec_t'{20'h00100, 1'b0, 2'd0, 20'hFFEFF, 1'b1, 1'b0, 20'h00100, 1'b1}, // R5 R6 masked bit latches
        vec_t'{20'h00000, 1'b0, 2'd0, 20'hFFFFF, 1'b1, 1'b0, 20'h00100, 1'b0}, // R6 unmask fires
        vec_t'{20'h00000, 1'b0, 2'd0, 20'hFFFFF, 1'b1, 1'b1, 20'h00100, 1'b1}, // R8 other source held
        vec_t'{20'h00800, 1'b0, 2'd0, 20'hFFFFF, 1'b1, 1'b1, 20'h00900, 1'b0}, // R8 cell error fires
        vec_t'{20'h00000, 1'b0, 2'd0, 20'hFFFFF, 1'b0, 1'b1, 20'h00900, 1'b1}, // R7 global off
        vec_t'{20'h01000, 1'b1, 2'd2, 20'hFFFFF, 1'b1, 1'b0, 20'h01100, 1'b0}, // R4 event beats clear
        vec_t'{20'h00000, 1'b1, 2'd1, 20'hFFFFF, 1'b1, 1'b0, 20'h01000, 1'b0}, // R3 port 1 read
        vec_t'{20'h00000, 1'b1, 2'd2, 20'hFFFFF, 1'b1, 1'b0, 20'h00000, 1'b1}, // R10 last read releases
        vec_t'{20'hFFFFF, 1'b0, 2'd0, 20'h00000, 1'b1, 1'b0, 20'hFFFFF, 1'b1}, // R5 R6 all masked
        vec_t'{20'h00000, 1'b1, 2'd3, 20'hFFFFF, 1'b1, 1'b0, 20'h07FFF, 1'b0}  // R3 port 3 read
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] evt = '0;
    logic          rd_stb = 1'b0;
    logic [1:0]    rd_addr = '0;
    logic [TW-1:0] mask = '0;
    logic          irq_en = 1'b0;
    logic          conly = 1'b0;
    logic [TW-1:0] status;
    logic          irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sticky_irq_ctrl #(
        .NUM_PORTS (NP),
        .NUM_SRC   (NS)
    ) u_dut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .evt_i           (evt),
        .rd_stb_i        (rd_stb),
        .rd_addr_i       (rd_addr),
        .src_mask_i      (mask),
        .irq_en_i        (irq_en),
        .cell_err_only_i (conly),
        .status_o        (status),
        .irq_n_o         (irq_n)
    );

    task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        step();
        check("R1 status in reset", status, '0);
        check("R1 irq in reset", TW'(irq_n), TW'(1'b1));
        rst_n = 1'b1;
        step();
        check("R1 status after reset", status, '0);
        check("R1 irq after reset", TW'(irq_n), TW'(1'b1));

        // Table walk: one stimulus cycle, then status check, then irq check.
        for (int i = 0; i < NV; i++) begin
            evt = VECS[i].ev;
            rd_stb = VECS[i].rd;
            rd_addr = VECS[i].addr;
            mask = VECS[i].mask;
            irq_en = VECS[i].en;
            conly = VECS[i].conly;
            step();
            check($sformatf("R2/R3/R4/R5 vec %0d status", i), status, VECS[i].exp_stat);
            evt = '0;
            rd_stb = 1'b0;
            step();
            check($sformatf("R6/R7/R8/R10 vec %0d irq", i), TW'(irq_n), TW'(VECS[i].exp_irq_n));
        end

        // Mid-run reset clears everything (R1).
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        check("R1 reset mid-run status", status, '0);
        check("R1 reset mid-run irq", TW'(irq_n), TW'(1'b1));

        // R9 fall latency: pulse at edge 1, irq falls at edge 2.
        mask = '1;
        irq_en = 1'b1;
        conly = 1'b0;
        step();
        evt = TW'(1);
        step();
        evt = '0;
        check("R9 irq still high after first edge", TW'(irq_n), TW'(1'b1));
        check("R2 status set", status, TW'(1));
        step();
        check("R9 irq low after second edge", TW'(irq_n), TW'(1'b0));
        repeat (5) step();
        check("R2 status held while idle", status, TW'(1));

        // R9 rise latency on the clearing read.
        rd_stb = 1'b1;
        rd_addr = 2'd0;
        step();
        rd_stb = 1'b0;
        check("R9 irq still low after read edge", TW'(irq_n), TW'(1'b0));
        check("R3 status cleared by read", status, '0);
        step();
        check("R9 R10 irq high after second edge", TW'(irq_n), TW'(1'b1));

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule